// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block runs a microprogram and drives the control bus of a datapath. The microprogram sits in an on-chip control store of 64-bit words. Software or a boot controller fills the store through a preload write port. Every word names the address of the word that follows it, and that address is held in a latch. No incrementing counter is involved.

Each microstep takes three clock cycles. The first phase latches the 24 level-type control bits and drives them out. The second phase latches the 40 pulse-type bits. The third phase returns the pulse bits to zero, so that no pulse reaches into the next step. In that same third phase the next address is chosen and the address latch is updated.

The level group also carries the sequencing fields. One field gives the plain next address and another gives a branch target. A two-bit condition select decides between them, using the zero flag or the carry/overflow flag of the ALU. A chosen address of zero means "fetch": the sequencer then dispatches to a slot whose address comes from the current opcode.

Top module: `useq_top`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `lvl_o`, `pls_o` and `uaddr_o` are zero and `phase_o` is 0.
- R2: `phase_o` cycles 0 (level latch), 1 (pulse latch), 2 (pulse clear) and back to 0, one phase per clock.
- R3: Word bits [23:0] appear on `lvl_o` in the cycle after a phase-0 cycle. This is one cycle before that word's pulse bits appear.
- R4: Word bits [63:24] appear on `pls_o` only while `phase_o` is 2. In phases 0 and 1, `pls_o` is zero.
- R5: `lvl_o` holds its value from the pulse-latch phase of one step until the pulse-latch phase of the next step.
- R6: The level field layout is: [7:0] next address, [15:8] branch target, [17:16] condition select. With select 00, the next address field is loaded.
- R7: With select 01, the branch target is loaded when `flag_z` is 1, and the next address field is loaded otherwise.
- R8: With select 10, the branch target is loaded when `flag_c` is 1, and the next address field is loaded otherwise.
- R9: With select 11, the branch target is always loaded.
- R10: If the chosen address is 0, the latch is loaded with `opcode` shifted left by 2 (four-word slots).
- R11: `uaddr_o` changes only at the clock edge that ends phase 2. The flags are sampled during phase 2.
- R12: A write through the preload port (`ld_en`, `ld_addr`, `ld_data`) replaces the stored word. The new word is used the next time that address is stepped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_z | input | 1 | ALU zero status |
| flag_c | input | 1 | ALU carry/overflow status |
| opcode | input | 4 | Current opcode, used for fetch dispatch |
| ld_en | input | 1 | Control store write enable |
| ld_addr | input | 8 | Control store write address |
| ld_data | input | 64 | Control store write word |
| lvl_o | output | 24 | Level-type control bits |
| pls_o | output | 40 | Pulse-type control bits |
| uaddr_o | output | 8 | Current microaddress |
| phase_o | output | 2 | Current phase within the step |

## Verification
The assertions check the timing rules on every cycle:
- the phase order;
- pulses that appear outside the clear phase;
- level bits or the address that move at the wrong edge;
- slot alignment after a fetch;
- loading the target on an unconditional jump.

Only the bench scenarios can show that the right words arrive in the right order. That covers each conditional branch both taken and not taken, dispatch from different opcodes, and a rewritten word taking effect. A reference model of the microprogram predicts each of these.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [1:0] {
    PH_LEVEL = 2'd0,
    PH_EDGE  = 2'd1,
    PH_CLEAR = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    BR_NONE   = 2'd0,
    BR_ZERO   = 2'd1,
    BR_CARRY  = 2'd2,
    BR_ALWAYS = 2'd3
  } brsel_e;
endpackage

// File: rtl/useq_phase.sv
module useq_phase
  import useq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_e phase
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_LEVEL;
    end else begin
      unique case (phase)
        PH_LEVEL: phase <= PH_EDGE;
        PH_EDGE:  phase <= PH_CLEAR;
        default:  phase <= PH_LEVEL;
      endcase
    end
  end

  AST_PHASE_LEVEL_TO_EDGE: assert property (@(posedge clk) disable iff (rst)
    phase == PH_LEVEL |=> phase == PH_EDGE); // R2
  AST_PHASE_EDGE_TO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    phase == PH_EDGE |=> phase == PH_CLEAR); // R2
  AST_PHASE_CLEAR_TO_LEVEL: assert property (@(posedge clk) disable iff (rst)
    phase == PH_CLEAR |=> phase == PH_LEVEL); // R2
endmodule

// File: rtl/useq_store.sv
module useq_store #(
  parameter int WORD_W = 64,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  // Simple dual-port RAM with a registered read port.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
  import useq_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int OPC_W    = 4,
  parameter int SLOT_LOG = 2,
  localparam int CTL_W   = 2 * ADDR_W + 2
) (
  input  logic [CTL_W-1:0]  ctl,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] nxt,
  output logic              fetch
);
  localparam int NXT_LSB = 0;
  localparam int TGT_LSB = ADDR_W;
  localparam int SEL_LSB = 2 * ADDR_W;

  logic [ADDR_W-1:0] f_next, f_tgt, cand, base;
  brsel_e            sel;
  logic              take;

  always_comb begin
    f_next = ctl[NXT_LSB +: ADDR_W];
    f_tgt  = ctl[TGT_LSB +: ADDR_W];
    sel    = brsel_e'(ctl[SEL_LSB +: 2]);
    unique case (sel)
      BR_ZERO:   take = flag_z;
      BR_CARRY:  take = flag_c;
      BR_ALWAYS: take = 1'b1;
      default:   take = 1'b0;
    endcase
    base  = ADDR_W'({opcode, {SLOT_LOG{1'b0}}});
    cand  = take ? f_tgt : f_next;
    fetch = (cand == '0);
    nxt   = fetch ? base : cand;
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
#(
  parameter int WORD_W   = 64,
  parameter int LEVEL_W  = 24,
  parameter int ADDR_W   = 8,
  parameter int OPC_W    = 4,
  parameter int SLOT_LOG = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      flag_z,
  input  logic                      flag_c,
  input  logic [OPC_W-1:0]          opcode,
  input  logic                      ld_en,
  input  logic [ADDR_W-1:0]         ld_addr,
  input  logic [WORD_W-1:0]         ld_data,
  output logic [LEVEL_W-1:0]        lvl_o,
  output logic [WORD_W-LEVEL_W-1:0] pls_o,
  output logic [ADDR_W-1:0]         uaddr_o,
  output logic [1:0]                phase_o
);
  localparam int PULSE_W = WORD_W - LEVEL_W;
  localparam int CTL_W   = 2 * ADDR_W + 2;
  localparam int TGT_LSB = ADDR_W;
  localparam int SEL_LSB = 2 * ADDR_W;

  phase_e            phase;
  logic [WORD_W-1:0] rd_word;
  logic [ADDR_W-1:0] rd_addr, nxt, uaddr_q;
  logic [LEVEL_W-1:0] lvl_q;
  logic [PULSE_W-1:0] pls_q;
  logic              fetch;

  useq_phase u_phase (
    .clk   (clk),
    .rst   (rst),
    .phase (phase)
  );

  // During the clear phase, look ahead so that the word for the next step
  // is ready when the next level-latch phase begins.
  assign rd_addr = (phase == PH_CLEAR) ? nxt : uaddr_q;

  useq_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .wr_en   (ld_en),
    .wr_addr (ld_addr),
    .wr_data (ld_data),
    .rd_addr (rd_addr),
    .rd_data (rd_word)
  );

  useq_nextaddr #(.ADDR_W(ADDR_W), .OPC_W(OPC_W), .SLOT_LOG(SLOT_LOG)) u_next (
    .ctl    (lvl_q[CTL_W-1:0]),
    .flag_z (flag_z),
    .flag_c (flag_c),
    .opcode (opcode),
    .nxt    (nxt),
    .fetch  (fetch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= '0;
      pls_q   <= '0;
      uaddr_q <= '0;
    end else begin
      unique case (phase)
        PH_LEVEL: lvl_q <= rd_word[LEVEL_W-1:0];
        PH_EDGE:  pls_q <= rd_word[WORD_W-1:LEVEL_W];
        default: begin
          pls_q   <= '0;
          uaddr_q <= nxt;
        end
      endcase
    end
  end

  assign lvl_o   = lvl_q;
  assign pls_o   = pls_q;
  assign uaddr_o = uaddr_q;
  assign phase_o = phase;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lvl_q == '0 && pls_q == '0 && uaddr_q == '0)); // R1
  AST_PULSE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (pls_q != '0) |-> phase == PH_CLEAR); // R4
  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    phase != PH_LEVEL |=> $stable(lvl_q)); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    phase != PH_CLEAR |=> $stable(uaddr_q)); // R11
  AST_FETCH_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CLEAR && fetch) |=> uaddr_q[SLOT_LOG-1:0] == '0); // R10
  AST_JUMP_ALWAYS: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_CLEAR && lvl_q[SEL_LSB +: 2] == BR_ALWAYS && lvl_q[TGT_LSB +: ADDR_W] != '0)
    |=> uaddr_q == $past(lvl_q[TGT_LSB +: ADDR_W])); // R9
endmodule

// File: tb/tb_useq_top.sv
module tb_useq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flag_z = 1'b0, flag_c = 1'b0;
  logic [3:0]  opcode = '0;
  logic        ld_en = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [63:0] ld_data = '0;
  logic [23:0] lvl_o;
  logic [39:0] pls_o;
  logic [7:0]  uaddr_o;
  logic [1:0]  phase_o;

  always #5 clk = ~clk;

  useq_top dut (
    .clk(clk), .rst(rst), .flag_z(flag_z), .flag_c(flag_c), .opcode(opcode),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .lvl_o(lvl_o), .pls_o(pls_o), .uaddr_o(uaddr_o), .phase_o(phase_o)
  );

  typedef struct packed {
    logic [1:0]  ph;
    logic [23:0] lv;
    logic [39:0] pl;
    logic [7:0]  ua;
    logic [7:0]  utag;
    logic [7:0]  ptag;
  } exp_t;

  exp_t        q[$];
  logic [63:0] prog [256];
  int          n_chk = 0, n_bad = 0;

  // Layout: [63:24] pulses, [23:18] spare level, [17:16] select, [15:8] target, [7:0] next
  function automatic logic [63:0] mkw(int nx, int tg, int sel, int ex, logic [39:0] pl);
    return {pl, 6'(ex), 2'(sel), 8'(tg), 8'(nx)};
  endfunction

  // Reference model of next-address choice (R6..R10)
  function automatic logic [7:0] model_next(logic [63:0] w, logic z, logic c,
                                            logic [3:0] opc, output int tag);
    logic [7:0] cand;
    logic       take;
    case (w[17:16])
      2'd1: begin take = z;    tag = 7; end
      2'd2: begin take = c;    tag = 8; end
      2'd3: begin take = 1'b1; tag = 9; end
      default: begin take = 1'b0; tag = 6; end
    endcase
    cand = take ? w[15:8] : w[7:0];
    if (cand == 8'd0) begin
      tag = 10;
      return {2'b00, opc, 2'b00};
    end
    return cand;
  endfunction

  task automatic chk(int tag, logic [63:0] act, logic [63:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic load(int a, logic [63:0] w);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 8'(a); ld_data = w;
    prog[a] = w;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // Driver: reset, push the predicted trace, release and wait for the monitor.
  task automatic run(logic [3:0] opc, logic z, logic c, int steps, int ptag);
    logic [7:0]  ea;
    logic [23:0] plv;
    logic [63:0] w;
    int          ut;
    @(negedge clk);
    rst = 1'b1; opcode = opc; flag_z = z; flag_c = c;
    repeat (3) @(negedge clk);
    chk(1, 64'(lvl_o), 64'd0, "reset lvl_o");     // R1
    chk(1, 64'(pls_o), 64'd0, "reset pls_o");     // R1
    chk(1, 64'(uaddr_o), 64'd0, "reset uaddr_o"); // R1
    chk(1, 64'(phase_o), 64'd0, "reset phase_o"); // R1
    ea = 8'd0; plv = '0; ut = 1;
    for (int s = 0; s < steps; s++) begin
      w = prog[ea];
      if (s > 0) q.push_back({2'd0, plv, 40'd0, ea, 8'(ut), 8'(ptag)});
      q.push_back({2'd1, w[23:0], 40'd0, ea, 8'd11, 8'(ptag)});
      q.push_back({2'd2, w[23:0], w[63:24], ea, 8'd11, 8'(ptag)});
      plv = w[23:0];
      ea = model_next(w, z, c, opc, ut);
    end
    rst = 1'b0;
    while (q.size() > 0) @(negedge clk);
  endtask

  // Monitor: sample 2 ns after each edge, compare against the scoreboard.
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (!rst && q.size() > 0) begin
      e = q.pop_front();
      chk(2, 64'(phase_o), 64'(e.ph), "phase");                               // R2
      chk((e.ph == 2'd1) ? 3 : 5, 64'(lvl_o), 64'(e.lv), "level bits");      // R3 R5
      chk(int'(e.ptag), 64'(pls_o), 64'(e.pl), "pulse bits");                // R4 R12
      chk(int'(e.utag), 64'(uaddr_o), 64'(e.ua), "microaddress");            // R6 R7 R8 R9 R10 R11
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) prog[i] = '0;
    load(0,  mkw(0,  0,  0, 6'h15, 40'h00_0000_0001));
    load(4,  mkw(5,  8,  1, 6'h2A, 40'hA5_0000_1234));
    load(5,  mkw(9,  12, 2, 6'h01, 40'h00_FF00_0000));
    load(8,  mkw(9,  12, 2, 6'h3F, 40'h80_0000_0001));
    load(9,  mkw(10, 16, 3, 6'h07, 40'h12_3456_789A));
    load(10, mkw(0,  0,  0, 6'h33, 40'h55_5555_5555));
    load(12, mkw(0,  0,  0, 6'h0C, 40'hFF_FFFF_FFFF));
    load(16, mkw(17, 0,  0, 6'h10, 40'h01_0203_0405));
    load(17, mkw(0,  0,  0, 6'h11, 40'h00_0000_8000));
    run(4'd1, 1'b0, 1'b0, 7, 4);   // R7 R8 not taken, R9 jump, R6, R10
    run(4'd1, 1'b1, 1'b1, 7, 4);   // R7 R8 taken
    run(4'd2, 1'b0, 1'b1, 6, 4);   // R10 other slot, R8 taken
    run(4'd1, 1'b1, 1'b0, 7, 4);   // R7 taken, R8 not taken
    load(16, mkw(17, 0, 0, 6'h2B, 40'hDE_ADBE_EF01)); // R12 rewrite
    run(4'd1, 1'b1, 1'b0, 7, 12);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule